// File: doc/BRIEF.md
# MSI Doorbell to Interrupt-Line Translator

This block turns message-signalled interrupt writes into interrupt lines for an upstream interrupt controller. A register slave port exposes an 8-byte doorbell window. Every write that lands anywhere in that window counts as a doorbell. The lowest byte of the write data carries a global vector number. The block subtracts a configured base vector from it, and the result selects one of `N_LINES` output lines. The selected line has a pending latch, and the write sets it. The latch stays set until the consumer pulses that line's acknowledge input.

Alongside the doorbell path, each output line has a wired interrupt input. This input is ORed straight onto the output at its current level, so a wired source and a doorbell source can share a line. A vector that falls below the base, or at or beyond the base plus `N_LINES`, is dropped. Such a write sets a sticky error flag instead. The line count is checked at elaboration: a value of zero or a value above 256 stops the build.

Top module: `msi_doorbell_xlat`

## Requirements
- R1: A write whose address falls in the 8-byte window starting at `WIN_BASE` (address bits above bit 2 equal) is a doorbell at every one of the eight offsets. A write outside the window changes no output.
- R2: The line index is `reg_wdata[7:0] - BASE_VEC`, the lowest-addressed byte in little-endian order. Bits 31:8 of the write data have no effect on which line is chosen.
- R3: A valid doorbell sets the selected line's pending latch. `irq_out` for that line is 1 from the clock edge that takes the write onward.
- R4: When `reg_wdata[7:0]` is below `BASE_VEC`, or is at or above `BASE_VEC + N_LINES`, the write is dropped and no pending latch changes. `err_flag` goes to 1 at that edge and stays 1 until reset.
- R5: `reg_rdata` is 0 for every read. A read changes no pending latch and does not change `err_flag`.
- R6: `irq_out[i]` equals `wired_irq[i]` OR the pending latch of line i, combinationally, following the wired input both as it rises and as it falls.
- R7: A 1 on `irq_ack[i]` at a clock edge clears the pending latch of line i at that edge.
- R8: A doorbell for line i and `irq_ack[i]` at the same edge leave line i pending.
- R9: A synchronous active-high `rst` clears all pending latches and `err_flag`, and reloads the base vector register from `BASE_VEC`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one access per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data, vector number in bits 7:0 |
| reg_rdata | output | 32 | Read data, always zero |
| wired_irq | input | N_LINES | Level interrupt inputs, one per line |
| irq_ack | input | N_LINES | Per-line acknowledge pulses |
| irq_out | output | N_LINES | Interrupt lines toward the upstream controller |
| err_flag | output | 1 | Sticky out-of-range doorbell indicator |

## Verification
A wrong subtraction or a wrong range boundary shows on `irq_out` at the first clock edge after the write. It appears either as the wrong bit set, or as a line set where `err_flag` should have risen. A pending latch that is lost or stuck shows one edge after a doorbell or an acknowledge, as the line bit staying low or staying high. A wired-path fault shows with no clock at all, in the same cycle the input moves. The bench sweeps all 256 vector values and all 256 wired patterns of an eight-line configuration, so every boundary of the window and the range is reached.

// File: rtl/msi_xlat_pkg.sv
package msi_xlat_pkg;

    localparam int MAX_LINES = 256;
    localparam int VEC_W     = 8;
    localparam int DATA_W    = 32;
    localparam int WIN_LSB   = 3;   // 8-byte doorbell window

    typedef logic [VEC_W-1:0] vec_t;

    // Decoded bus access toward the translator
    typedef struct packed {
        logic db_fire;   // write landed in the window
        logic rd_hit;    // read landed in the window
        vec_t vec;       // little-endian low byte of the write data
    } db_req_t;

    // Result of the vector translation
    typedef struct packed {
        logic ok;        // index is in range
        logic bad;       // doorbell dropped
        vec_t idx;       // line index when ok
    } xlat_res_t;

    function automatic logic lines_legal(input int n);
        return (n >= 1) && (n <= MAX_LINES);
    endfunction

    // Signed subtraction with range test against the line count
    function automatic xlat_res_t translate(input vec_t vec, input vec_t base,
                                            input int n, input logic fire);
        xlat_res_t  r;
        logic [8:0] diff;
        logic [8:0] lim;
        diff  = {1'b0, vec} - {1'b0, base};
        lim   = 9'(n);
        r.idx = diff[7:0];
        r.ok  = fire && !diff[8] && ({1'b0, diff[7:0]} < lim);
        r.bad = fire && !r.ok;
        return r;
    endfunction

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
    import msi_xlat_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] WIN_BASE = 12'h100
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output db_req_t           req
);
    localparam int TAG_W = ADDR_W - WIN_LSB;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [TAG_W-1:0]  WIN_TAG = BASE_A[ADDR_W-1:WIN_LSB];

    logic win_hit;

    always_comb begin
        win_hit     = (reg_addr[ADDR_W-1:WIN_LSB] == WIN_TAG);
        req.db_fire = win_hit && reg_wr;
        req.rd_hit  = win_hit && reg_rd && !reg_wr;
        req.vec     = reg_wdata[VEC_W-1:0];
        reg_rdata   = '0;
    end

    // Upper data bits and the low address bits select nothing.
    logic unused_bits;
    assign unused_bits = ^{reg_wdata[DATA_W-1:VEC_W], reg_addr[WIN_LSB-1:0]};

endmodule

// File: rtl/msi_vec_xlat.sv
module msi_vec_xlat
    import msi_xlat_pkg::*;
#(
    parameter int   N_LINES  = 8,
    parameter logic [7:0] BASE_VEC = 8'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  db_req_t            req,
    output logic [N_LINES-1:0] set_vec,
    output logic               drop
);
    vec_t      base_q;
    xlat_res_t res;

    always_ff @(posedge clk) begin
        if (rst) base_q <= BASE_VEC;
    end

    always_comb res = translate(req.vec, base_q, N_LINES, req.db_fire);
    assign drop = res.bad;

    for (genvar i = 0; i < N_LINES; i++) begin : g_sel
        assign set_vec[i] = res.ok && (res.idx == VEC_W'(i));
    end

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        base_q == BASE_VEC) else $error("base vector moved");  // R9
    AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_vec)) else $error("more than one line selected");  // R3

endmodule

// File: rtl/msi_line_bank.sv
module msi_line_bank
    import msi_xlat_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] set_vec,
    input  logic               drop,
    input  logic [N_LINES-1:0] irq_ack,
    input  logic [N_LINES-1:0] wired_irq,
    output logic [N_LINES-1:0] irq_out,
    output logic               err_flag
);
    logic [N_LINES-1:0] pend_q;
    logic               err_q;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)             pend_q[i] <= 1'b0;
            else if (set_vec[i]) pend_q[i] <= 1'b1;   // set wins over ack
            else if (irq_ack[i]) pend_q[i] <= 1'b0;
        end

        AST_SET_OVER_ACK: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> pend_q[i]) else $error("doorbell lost");  // R8
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (irq_ack[i] && !set_vec[i]) |=> !pend_q[i]) else $error("ack ignored");  // R7
    end

    always_ff @(posedge clk) begin
        if (rst)       err_q <= 1'b0;
        else if (drop) err_q <= 1'b1;
    end

    assign irq_out  = pend_q | wired_irq;
    assign err_flag = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q) else $error("error flag dropped");  // R4
    AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        drop |=> (pend_q == ($past(pend_q) & ~$past(irq_ack))))
        else $error("dropped doorbell touched a line");  // R4

endmodule

// File: rtl/msi_doorbell_xlat.sv
module msi_doorbell_xlat
    import msi_xlat_pkg::*;
#(
    parameter int          N_LINES  = 8,
    parameter logic [7:0]  BASE_VEC = 8'h40,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] WIN_BASE = 12'h100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [N_LINES-1:0] wired_irq,
    input  logic [N_LINES-1:0] irq_ack,
    output logic [N_LINES-1:0] irq_out,
    output logic               err_flag
);
    // Reject an illegal line count while elaborating.
    if (!lines_legal(N_LINES)) begin : g_bad_cfg
        $error("N_LINES must lie in 1..256");
    end

    db_req_t            req;
    logic [N_LINES-1:0] set_vec;
    logic               drop;

    msi_db_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req      (req)
    );

    msi_vec_xlat #(.N_LINES(N_LINES), .BASE_VEC(BASE_VEC)) u_xlat (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .set_vec(set_vec),
        .drop   (drop)
    );

    msi_line_bank #(.N_LINES(N_LINES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .drop     (drop),
        .irq_ack  (irq_ack),
        .wired_irq(wired_irq),
        .irq_out  (irq_out),
        .err_flag (err_flag)
    );

    AST_DB_RAISES: assert property (@(posedge clk) disable iff (rst)
        (|set_vec) |=> ((irq_out & $past(set_vec)) == $past(set_vec)))
        else $error("doorbell line not raised");  // R3
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        req.rd_hit |-> (set_vec == '0 && !drop))
        else $error("read acted as doorbell");  // R5

endmodule

// File: tb/msi_doorbell_xlat_tb.sv
`timescale 1ns/1ps
module msi_doorbell_xlat_tb;
    localparam int          N   = 8;
    localparam logic [7:0]  BV  = 8'h40;
    localparam logic [11:0] WB  = 12'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] wired_irq = '0, irq_ack = '0, irq_out;
    logic        err_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    msi_doorbell_xlat #(.N_LINES(N), .BASE_VEC(BV), .ADDR_W(12), .WIN_BASE(WB)) u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wired_irq(wired_irq),
        .irq_ack(irq_ack), .irq_out(irq_out), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write takes effect at the posedge between the two negedges.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic ack(input logic [N-1:0] m);
        @(negedge clk); irq_ack = m;
        @(negedge clk); irq_ack = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic exp_err;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 out", 32'(irq_out), 0);
        chk("R9 err", 32'(err_flag), 0);

        // R6: all wired patterns pass through combinationally
        for (int p = 0; p < 256; p++) begin
            wired_irq = N'(p); #1;
            chk("R6 wired", 32'(irq_out), 32'(p));
        end
        wired_irq = '0; #1;
        chk("R6 wired fall", 32'(irq_out), 0);

        // R1: every offset in the window rings
        for (int o = 0; o < 8; o++) begin
            wr(WB + 12'(o), 32'(BV) + 32'(o));
            chk("R1 offset", 32'(irq_out), 32'(1) << o);
            ack(N'(1) << o);
            chk("R7 ack", 32'(irq_out), 0);
        end
        // R1: just outside the window on both sides
        wr(WB + 12'd8, 32'(BV));
        chk("R1 above window", 32'(irq_out), 0);
        wr(WB - 12'd1, 32'(BV));
        chk("R1 below window", 32'(irq_out), 0);
        chk("R1 no err", 32'(err_flag), 0);

        // R2/R3/R4/R7: sweep all vector values with noisy upper bits
        exp_err = 1'b0;
        for (int v = 0; v < 256; v++) begin
            logic ok;
            ok = (v >= int'(BV)) && (v < int'(BV) + N);
            if (!ok) exp_err = 1'b1;
            wr(WB + 12'(v % 8), {8'(v) ^ 8'h5a, 8'(v * 3), 8'hc3, 8'(v)});
            chk(ok ? "R2 R3 line" : "R4 dropped", 32'(irq_out),
                ok ? (32'(1) << (v - int'(BV))) : 0);
            chk("R4 err", 32'(err_flag), 32'(exp_err));
            if (ok) begin
                ack(N'(1) << (v - int'(BV)));
                chk("R7 cleared", 32'(irq_out), 0);
            end
        end

        // R5: read with pending line and write-like data
        wr(WB, 32'(BV) + 3);
        @(negedge clk); reg_addr = WB + 12'd4; reg_wdata = 32'(BV) + 5; reg_rd = 1'b1; #1;
        chk("R5 rdata", reg_rdata, 0);
        @(negedge clk); reg_rd = 1'b0;
        chk("R5 no effect", 32'(irq_out), 32'h8);
        chk("R5 err kept", 32'(err_flag), 1);
        ack(8'h08);

        // R8: doorbell and ack for the same line in one cycle
        @(negedge clk); reg_addr = WB; reg_wdata = 32'(BV) + 2; reg_wr = 1'b1; irq_ack = 8'h04;
        @(negedge clk); reg_wr = 1'b0; irq_ack = '0;
        chk("R8 kept", 32'(irq_out), 32'h4);
        ack(8'h04);
        chk("R8 then cleared", 32'(irq_out), 0);

        // R6: pending ORed with wired on the same line
        wr(WB, 32'(BV) + 1);
        wired_irq = 8'h02; #1;
        chk("R6 or", 32'(irq_out), 32'h2);
        wired_irq = 8'h00; #1;
        chk("R6 pending holds", 32'(irq_out), 32'h2);
        ack(8'h02);
        chk("R6 both low", 32'(irq_out), 0);

        // R9: reset clears pending and error
        wr(WB, 32'(BV) + 7);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 pend cleared", 32'(irq_out), 0);
        chk("R9 err cleared", 32'(err_flag), 0);
        wr(WB, 32'(BV) + 6);
        chk("R9 base reloaded", 32'(irq_out), 32'h40);

        finish_run();
    end
endmodule